// File: doc/BRIEF.md
# Fixed Off-Time Bridge Current Chopper

This block sits between a PWM gate generator and the gate drivers of a multi-phase half-bridge. When the bridge current is too high, it takes over the gate requests for a fixed time. Otherwise the gate requests pass through unchanged. A digital comparator bit reports when the sense voltage is above the trip level. That bit must stay high for a number of consecutive clock cycles before it counts as a trip. Trips are also ignored for a blanking window after every PWM switching edge, because a switching edge causes a false spike on the sense input.

An accepted trip starts a fixed sequence. First every low-side switch turns off and a dead interval follows. Next comes the off phase: the high-side switch turns on in every leg whose low side was requested, so the motor current recirculates through the high-side devices. A second dead interval then lets the high sides turn off before the low sides come back. Normal drive then resumes, and a fresh blanking window starts. A trip that arrives while the sequence runs has no effect. All lengths are parameters counted in system clock cycles.

Top module: `chop_current_limiter`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `chopping` is 0 and both gate outputs equal their requests.
- R2: While not chopping, `hs_gate` equals `hs_req` and `ls_gate` equals `ls_req` in the same cycle.
- R3: The trip input counts only after FILT_LEN consecutive sampled high cycles. A shorter pulse never starts a chop.
- R4: A `pwm_edge` pulse sampled high opens a blanking window of BLANK_CYC cycles. During that window a filtered trip is ignored.
- R5: A filtered trip seen outside blanking raises `chopping` on the next cycle. For DEAD_CYC cycles every `ls_gate` bit is then 0 and `hs_gate` equals `hs_req`.
- R6: For the next OFF_CYC cycles (the off phase), `ls_gate` is 0 and each `hs_gate` bit is the OR of that phase's high-side and low-side requests.
- R7: For the next DEAD_CYC cycles after the off phase, `ls_gate` is 0 and `hs_gate` equals `hs_req`. After that, `chopping` falls.
- R8: Every chop holds `chopping` high for exactly 2*DEAD_CYC+OFF_CYC cycles. A trip that arrives while a chop runs does not lengthen it.
- R9: When a chop ends, a blanking window of BLANK_CYC cycles starts, just as a PWM edge would start one.
- R10: If no phase requests its high and low side together, no phase drives both gates together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trip_raw | input | 1 | Over-current comparator bit, high when above threshold |
| pwm_edge | input | 1 | One-cycle pulse on each PWM switching edge |
| hs_req | input | PHASES | High-side gate requests, bit i = phase i |
| ls_req | input | PHASES | Low-side gate requests, bit i = phase i |
| hs_gate | output | PHASES | High-side gate commands after chopping |
| ls_gate | output | PHASES | Low-side gate commands after chopping |
| chopping | output | 1 | High while a chop sequence is in progress |

## Verification
A wrong phase counter shows at the gate ports on the cycle it diverges. A chop that is too short or too long changes the edge where `chopping` falls, and it changes when the high side in a recirculating leg drops. A corrupt filter count or blanking count does not show until the next trip. It then appears as a chop that starts one or more cycles early or late, or one that never starts. For this reason the stimulus puts trips just inside and just outside both windows.

// File: rtl/chop_pkg.sv
// Shared types for the current chopper.
package chop_pkg;
    // Phases of a chop sequence; CH_IDLE means requests pass through.
    typedef enum logic [1:0] {
        CH_IDLE     = 2'd0,
        CH_DEAD_IN  = 2'd1,
        CH_OFF      = 2'd2,
        CH_DEAD_OUT = 2'd3
    } chop_state_e;
endpackage

// File: rtl/chop_trip_filter.sv
// Digital time filter on the comparator bit: trip_ok is high once the raw
// input has been sampled high FILT_LEN times in a row. Assumes trip_raw is
// already synchronous to clk.
module chop_trip_filter #(
    parameter int FILT_LEN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trip_raw,
    output logic trip_ok
);
    localparam int W = $clog2(FILT_LEN + 1);
    localparam logic [W-1:0] FULL = W'(FILT_LEN);

    logic [W-1:0] run_q;

    // Count consecutive high samples, saturating at FULL.
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_q <= '0;
        else if (!trip_raw)
            run_q <= '0;
        else if (run_q != FULL)
            run_q <= run_q + 1'b1;
    end

    assign trip_ok = (run_q == FULL);
endmodule

// File: rtl/chop_blank_timer.sv
// Leading-edge blanking: each restart pulse opens a window of BLANK_CYC
// cycles during which blanking is high. Assumes restart is one cycle wide.
module chop_blank_timer #(
    parameter int BLANK_CYC = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic blanking
);
    localparam int W = $clog2(BLANK_CYC + 1);

    logic [W-1:0] left_q;

    // Reload on restart, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            left_q <= '0;
        else if (restart)
            left_q <= W'(BLANK_CYC);
        else if (left_q != '0)
            left_q <= left_q - 1'b1;
    end

    assign blanking = (left_q != '0);
endmodule

// File: rtl/chop_offtime_fsm.sv
// Sequencer for one chop: dead-in, fixed off phase, dead-out, then idle.
// Trips are only sampled in idle, so a running sequence cannot restart.
// Assumes DEAD_CYC >= 1 and OFF_CYC >= 1.
module chop_offtime_fsm
    import chop_pkg::*;
#(
    parameter int DEAD_CYC = 64,
    parameter int OFF_CYC  = 960
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        trip_ok,
    input  logic        blanking,
    output chop_state_e state,
    output logic        resume_done
);
    localparam int MAXC = (DEAD_CYC > OFF_CYC) ? DEAD_CYC : OFF_CYC;
    localparam int W    = $clog2(MAXC + 1);

    chop_state_e  state_q;
    logic [W-1:0] cnt_q;
    logic         accept;

    assign accept      = (state_q == CH_IDLE) && trip_ok && !blanking;
    assign resume_done = (state_q == CH_DEAD_OUT) && (cnt_q == '0);

    // Advance the phase when its down-counter expires.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CH_IDLE;
            cnt_q   <= '0;
        end else begin
            unique case (state_q)
                CH_IDLE: if (accept) begin
                    state_q <= CH_DEAD_IN;
                    cnt_q   <= W'(DEAD_CYC - 1);
                end
                CH_DEAD_IN: if (cnt_q == '0) begin
                    state_q <= CH_OFF;
                    cnt_q   <= W'(OFF_CYC - 1);
                end else cnt_q <= cnt_q - 1'b1;
                CH_OFF: if (cnt_q == '0) begin
                    state_q <= CH_DEAD_OUT;
                    cnt_q   <= W'(DEAD_CYC - 1);
                end else cnt_q <= cnt_q - 1'b1;
                CH_DEAD_OUT: if (cnt_q == '0) begin
                    state_q <= CH_IDLE;
                end else cnt_q <= cnt_q - 1'b1;
                default: state_q <= CH_IDLE;
            endcase
        end
    end

    assign state = state_q;
endmodule

// File: rtl/chop_gate_mux.sv
// Per-phase gate override: pass-through in idle, low side off in both dead
// intervals, low-side request steered to the high side in the off phase.
module chop_gate_mux
    import chop_pkg::*;
#(
    parameter int PHASES = 3
) (
    input  chop_state_e       state,
    input  logic [PHASES-1:0] hs_req,
    input  logic [PHASES-1:0] ls_req,
    output logic [PHASES-1:0] hs_gate,
    output logic [PHASES-1:0] ls_gate
);
    for (genvar p = 0; p < PHASES; p++) begin : g_leg
        // Select this leg's gate pair from the chop phase.
        always_comb begin
            unique case (state)
                CH_IDLE: begin
                    hs_gate[p] = hs_req[p];
                    ls_gate[p] = ls_req[p];
                end
                CH_OFF: begin
                    hs_gate[p] = hs_req[p] | ls_req[p];
                    ls_gate[p] = 1'b0;
                end
                default: begin
                    hs_gate[p] = hs_req[p];
                    ls_gate[p] = 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/chop_current_limiter.sv
// Fixed off-time current chopper with filtered trip input, leading-edge
// blanking and high-side recirculation. Assumes all inputs are synchronous
// to clk; times are counted in clk cycles (defaults sized for 40 MHz).
module chop_current_limiter
    import chop_pkg::*;
#(
    parameter int PHASES    = 3,
    parameter int FILT_LEN  = 8,
    parameter int BLANK_CYC = 32,
    parameter int DEAD_CYC  = 64,
    parameter int OFF_CYC   = 960
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trip_raw,
    input  logic              pwm_edge,
    input  logic [PHASES-1:0] hs_req,
    input  logic [PHASES-1:0] ls_req,
    output logic [PHASES-1:0] hs_gate,
    output logic [PHASES-1:0] ls_gate,
    output logic              chopping
);
    logic        trip_ok;
    logic        blanking;
    logic        resume_done;
    chop_state_e state;

    chop_trip_filter #(.FILT_LEN(FILT_LEN)) u_filt (
        .clk(clk), .rst_n(rst_n), .trip_raw(trip_raw), .trip_ok(trip_ok)
    );

    chop_blank_timer #(.BLANK_CYC(BLANK_CYC)) u_blank (
        .clk(clk), .rst_n(rst_n), .restart(pwm_edge | resume_done),
        .blanking(blanking)
    );

    chop_offtime_fsm #(.DEAD_CYC(DEAD_CYC), .OFF_CYC(OFF_CYC)) u_fsm (
        .clk(clk), .rst_n(rst_n), .trip_ok(trip_ok), .blanking(blanking),
        .state(state), .resume_done(resume_done)
    );

    chop_gate_mux #(.PHASES(PHASES)) u_mux (
        .state(state), .hs_req(hs_req), .ls_req(ls_req),
        .hs_gate(hs_gate), .ls_gate(ls_gate)
    );

    assign chopping = (state != CH_IDLE);
endmodule

// File: rtl/chop_current_limiter_chk.sv
// Property checker for chop_current_limiter, attached by bind below.
module chop_current_limiter_chk #(
    parameter int PHASES    = 3,
    parameter int DEAD_CYC  = 64,
    parameter int OFF_CYC   = 960
) (
    input logic              clk,
    input logic              rst_n,
    input logic [PHASES-1:0] hs_req,
    input logic [PHASES-1:0] ls_req,
    input logic [PHASES-1:0] hs_gate,
    input logic [PHASES-1:0] ls_gate,
    input logic              chopping,
    input logic              trip_ok,
    input logic              blanking
);
    localparam int TOTAL = 2 * DEAD_CYC + OFF_CYC;

    logic [31:0] run_len;

    // Length of the current chopping run.
    always_ff @(posedge clk) begin
        if (!rst_n) run_len <= '0;
        else        run_len <= chopping ? run_len + 1 : '0;
    end

    // R5
    start_on_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chopping) |-> $past(trip_ok && !blanking));

    // R6
    low_side_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chopping |-> (ls_gate == '0));

    // R8
    fixed_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(chopping) |-> (run_len == TOTAL));

    // R9
    reblank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(chopping) |-> blanking);

    // R10
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((hs_req & ls_req) == '0) |-> ((hs_gate & ls_gate) == '0));
endmodule

bind chop_current_limiter chop_current_limiter_chk #(
    .PHASES(PHASES), .DEAD_CYC(DEAD_CYC), .OFF_CYC(OFF_CYC)
) u_chk (
    .clk(clk), .rst_n(rst_n), .hs_req(hs_req), .ls_req(ls_req),
    .hs_gate(hs_gate), .ls_gate(ls_gate), .chopping(chopping),
    .trip_ok(trip_ok), .blanking(blanking)
);

// File: tb/sim_chop_current_limiter.sv
module sim_chop_current_limiter;
    localparam int PH = 3, FL = 3, BL = 6, DC = 2, OC = 20;
    localparam int TOTAL = 2 * DC + OC;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n = 1'b0, trip_raw = 1'b0, pwm_edge = 1'b0;
    logic [PH-1:0] hs_req = '0, ls_req = '0, hs_gate, ls_gate;
    logic          chopping;

    chop_current_limiter #(.PHASES(PH), .FILT_LEN(FL), .BLANK_CYC(BL),
                           .DEAD_CYC(DC), .OFF_CYC(OC)) u0 (
        .clk(clk), .rst_n(rst_n), .trip_raw(trip_raw), .pwm_edge(pwm_edge),
        .hs_req(hs_req), .ls_req(ls_req), .hs_gate(hs_gate),
        .ls_gate(ls_gate), .chopping(chopping)
    );

    int checks = 0, fails = 0;
    // behavioural model: high-run length, blank cycles left, phase, cycles in phase
    int m_run = 0, m_blank = 0, m_phase = 0, m_age = 0;
    int run_len = 0, since_end = 1000;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = 0; m_blank = 0; m_phase = 0; m_age = 0;
        end else begin
            bit take, fin;
            take = (m_phase == 0) && (m_run >= FL) && (m_blank == 0);
            fin  = (m_phase == 3) && (m_age == DC - 1);
            m_run = trip_raw ? m_run + 1 : 0;
            if (pwm_edge || fin) m_blank = BL;
            else if (m_blank > 0) m_blank--;
            if (take) begin m_phase = 1; m_age = 0; end
            else if (m_phase == 1 && m_age == DC - 1) begin m_phase = 2; m_age = 0; end
            else if (m_phase == 2 && m_age == OC - 1) begin m_phase = 3; m_age = 0; end
            else if (fin) begin m_phase = 0; m_age = 0; end
            else if (m_phase != 0) m_age++;
        end
    end

    task automatic check(string tag, string what, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, got, exp, $time);
        end
    endtask

    task automatic compare();
        string tag;
        logic [PH-1:0] eh, el;
        case (m_phase)
            0: begin tag = rst_n ? "R2" : "R1"; eh = hs_req; el = ls_req; end
            1: begin tag = "R5"; eh = hs_req; el = '0; end
            2: begin tag = "R6"; eh = hs_req | ls_req; el = '0; end
            default: begin tag = "R7"; eh = hs_req; el = '0; end
        endcase
        check(tag, "hs_gate", 32'(hs_gate), 32'(eh));
        check(tag, "ls_gate", 32'(ls_gate), 32'(el));
        check(tag, "chopping", 32'(chopping), 32'(m_phase != 0));
        if ((hs_req & ls_req) == '0)
            check("R10", "overlap", 32'(hs_gate & ls_gate), 32'd0);
        if (chopping) run_len++;
        else begin
            if (run_len > 0) begin
                check("R8", "chop length", 32'(run_len), 32'(TOTAL));
                since_end = 0;
            end
            run_len = 0;
        end
        if (since_end < BL) begin
            check("R9", "reblank", 32'(chopping), 32'd0);
            since_end++;
        end
    endtask

    task automatic cyc(input logic t, input logic e, input logic [PH-1:0] h, input logic [PH-1:0] l);
        @(negedge clk);
        trip_raw = t; pwm_edge = e; hs_req = h; ls_req = l;
        #1 compare();
    endtask

    initial begin
        #(8 * 100000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        // R1: reset with varied requests
        cyc(0, 0, 3'b001, 3'b010);
        cyc(1, 1, 3'b100, 3'b001);
        cyc(1, 0, 3'b010, 3'b100);
        @(negedge clk); rst_n = 1'b1;
        cyc(0, 0, 3'b001, 3'b010);
        check("R1", "chopping after reset", 32'(chopping), 32'd0);
        // R2: pass-through patterns
        for (int i = 0; i < 8; i++) cyc(0, i[0], 3'(i), 3'(~i));
        // R3: pulse one short of the filter length
        cyc(1, 0, 3'b001, 3'b010);
        cyc(1, 0, 3'b001, 3'b010);
        for (int i = 0; i < 6; i++) cyc(0, 0, 3'b001, 3'b010);
        check("R3", "short pulse ignored", 32'(chopping), 32'd0);
        // R4: trip fully filtered but inside blanking
        cyc(1, 1, 3'b010, 3'b100);
        for (int i = 0; i < 4; i++) cyc(1, 0, 3'b010, 3'b100);
        for (int i = 0; i < 8; i++) cyc(0, 0, 3'b010, 3'b100);
        check("R4", "blanked trip ignored", 32'(chopping), 32'd0);
        // R5-R8: long trip, requests change during off phase
        for (int i = 0; i < 10; i++) cyc(1, 0, 3'b001, 3'b010);
        for (int i = 0; i < 10; i++) cyc(1, 0, 3'b100, 3'b001);
        for (int i = 0; i < 20; i++) cyc(0, 0, 3'b100, 3'b011);
        // R8/R9: trip held through chop end; re-trip only after blanking
        for (int i = 0; i < 70; i++) cyc(1, 0, 3'b010, 3'b101);
        for (int i = 0; i < 30; i++) cyc(0, 0, 3'b010, 3'b101);
        // trip released right as blanking ends, and periodic PWM edges
        for (int k = 0; k < 6; k++) begin
            cyc(0, 1, 3'b001, 3'b110);
            for (int i = 0; i < k + 4; i++) cyc(1, 0, 3'b001, 3'b110);
            for (int i = 0; i < 30; i++) cyc(0, 0, 3'b110, 3'b001);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule